// File: doc/BRIEF.md
# SDRAM Burst Data Path

This block carries burst data between a host's write/read data ports and the data pins of a single-data-rate SDRAM. A separate command sequencer issues the memory commands; this block only watches the sequencer's acknowledge pulse and the configured row-to-column delay (RCD) and CAS latency (CL). From these it lines up each data beat with the memory's write or read cycle. The block owns no memory commands of its own.

On a write, the first host word and its byte mask are taken during the acknowledge cycle. The later words arrive on a fixed schedule, pass through a short delay pipeline, and are driven onto the memory data pins with the output enable raised for exactly the burst beats. On a read, the data pins are sampled at the CL-adjusted beat cycles and registered once more. The words then reach the host one per clock, each marked by a valid flag. A burst is either a fixed length of 1, 2, 4 or 8 words, or, in page mode, open-ended until the sequencer signals a stop.

Top module: `sdram_dpath`

## Requirements
- R1: While reset is asserted and after its release with no acknowledge, `dq_oe_o`, `dqm_o` and `host_rvalid_o` are all low.
- R2: For a write, the word and mask on the host ports in the acknowledge cycle (cycle 0) appear on `dq_o`/`dqm_o` in cycle RCD.
- R3: For a write, host word k (k >= 1) is sampled in cycle RCD-2+k and appears on `dq_o` in cycle RCD+k. Beats are consecutive.
- R4: `dqm_o` bit i carries the host mask bit for byte lane i (`dq_o` bits 8i+7..8i) of the same beat, with the mask width DW/8. Outside write beats `dqm_o` is all zero.
- R5: `dq_oe_o` is high in exactly the write-beat cycles and falls in the cycle after the last beat.
- R6: For a read, `dq_i` is sampled in cycle RCD+CL+k, and that word appears on `host_rdata_o` with `host_rvalid_o` high in cycle RCD+CL+2+k.
- R7: With page mode off, a burst has `cfg_blen_i` beats, where the field holds the binary count 1, 2, 4 or 8.
- R8: With page mode on, `cfg_blen_i` is ignored. `stop_i` high in cycle RCD-1+m of a write, or in cycle RCD+CL+m of a read, makes beat m the last one.
- R9: During a read, `dq_oe_o` stays low and `dqm_o` stays zero.
- R10: `cfg_cl_i` and `cfg_rcd_i` are plain binary clock counts, each 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_i | input | 1 | Sequencer acknowledge pulse, marks cycle 0 |
| ack_wr_i | input | 1 | Direction qualifier with `ack_i`: 1 write, 0 read |
| stop_i | input | 1 | Page-mode burst stop |
| cfg_cl_i | input | 2 | CAS latency in clocks |
| cfg_rcd_i | input | 2 | Row-to-column delay in clocks |
| cfg_blen_i | input | 4 | Burst length count |
| cfg_page_i | input | 1 | Page mode enable |
| host_wdata_i | input | DW | Host write data |
| host_mask_i | input | DW/8 | Host byte mask, high blocks a lane |
| host_rdata_o | output | DW | Host read data |
| host_rvalid_o | output | 1 | Read beat valid |
| dq_i | input | DW | Memory data pins, input side |
| dq_o | output | DW | Memory data pins, output side |
| dq_oe_o | output | 1 | Memory data pin driver enable |
| dqm_o | output | DW/8 | Memory byte mask |

## Verification
Every combination of CL, RCD and fixed burst length is swept for both directions. Each host and pin word carries its test and beat index, so an off-by-one cycle in either pipeline shows up as a wrong value, not just a wrong strobe. Words offered outside their sampling window are replaced by a distinct filler pattern; any early or late sample therefore returns the filler. Page-mode runs set a burst length that disagrees with the stop point, which separates a stop-driven end from a length-driven one. Stops at the first beat and at a later beat show that the stop lands on the intended beat.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [1:0] {
    TM_IDLE  = 2'd0,
    TM_WAIT  = 2'd1,
    TM_BURST = 2'd2
  } tm_state_e;

  localparam int DIR_WR = 0;
  localparam int DIR_RD = 1;
endpackage

// File: rtl/sdp_beat_timer.sv
module sdp_beat_timer
  import sdp_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  delay_i,
  input  logic [BEAT_W-1:0] blen_i,
  input  logic              page_i,
  input  logic              stop_i,
  output logic              fire_o
);
  tm_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              burst_end;

  // fixed burst ends on its last count, page burst on the stop strobe
  assign burst_end = page_i ? stop_i : (beat_q == (blen_i - BEAT_W'(1)));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    beat_d  = beat_q;
    case (state_q)
      TM_IDLE: begin
        if (start_i) begin
          if (delay_i <= CNT_W'(1)) begin
            state_d = TM_BURST;
            beat_d  = '0;
          end else begin
            state_d = TM_WAIT;
            cnt_d   = delay_i - CNT_W'(1);
          end
        end
      end
      TM_WAIT: begin
        if (cnt_q <= CNT_W'(1)) begin
          state_d = TM_BURST;
          beat_d  = '0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      TM_BURST: begin
        beat_d = beat_q + BEAT_W'(1);
        if (burst_end) state_d = TM_IDLE;
      end
      default: state_d = TM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TM_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
    end
  end

  assign fire_o = (state_q == TM_BURST);
endmodule

// File: rtl/sdp_wr_lane.sv
module sdp_wr_lane #(
  parameter int DW = 32,
  parameter int MW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic          fire_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [MW-1:0] mask_i,
  output logic [DW-1:0] dq_o,
  output logic [MW-1:0] dqm_o,
  output logic          oe_o
);
  logic [DW-1:0] head_q, pipe_q, dq_q, dq_d;
  logic [MW-1:0] hmask_q, pmask_q, dqm_q, dqm_d;
  logic          fire_q, oe_q, first_beat;

  // a beat with no beat before it takes the word held from the acknowledge
  assign first_beat = fire_i && !fire_q;

  always_comb begin
    dq_d  = dq_q;
    dqm_d = '0;
    if (fire_i) begin
      dq_d  = first_beat ? head_q  : pipe_q;
      dqm_d = first_beat ? hmask_q : pmask_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      hmask_q <= '0;
      pipe_q  <= '0;
      pmask_q <= '0;
      fire_q  <= 1'b0;
      dq_q    <= '0;
      dqm_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (cap_i) begin
        head_q  <= wdata_i;
        hmask_q <= mask_i;
      end
      pipe_q  <= wdata_i;
      pmask_q <= mask_i;
      fire_q  <= fire_i;
      dq_q    <= dq_d;
      dqm_q   <= dqm_d;
      oe_q    <= fire_i;
    end
  end

  assign dq_o  = dq_q;
  assign dqm_o = dqm_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/sdp_rd_lane.sv
module sdp_rd_lane #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic [DW-1:0] cap_q, out_q;
  logic          cap_v_q, out_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      cap_v_q <= 1'b0;
      out_q   <= '0;
      out_v_q <= 1'b0;
    end else begin
      if (fire_i)  cap_q <= dq_i;
      cap_v_q <= fire_i;
      if (cap_v_q) out_q <= cap_q;
      out_v_q <= cap_v_q;
    end
  end

  assign rdata_o  = out_q;
  assign rvalid_o = out_v_q;
endmodule

// File: rtl/sdram_dpath.sv
module sdram_dpath
  import sdp_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CL_W  = 2,
  parameter int RCD_W = 2,
  parameter int BL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_i,
  input  logic              ack_wr_i,
  input  logic              stop_i,
  input  logic [CL_W-1:0]   cfg_cl_i,
  input  logic [RCD_W-1:0]  cfg_rcd_i,
  input  logic [BL_W-1:0]   cfg_blen_i,
  input  logic              cfg_page_i,
  input  logic [DW-1:0]     host_wdata_i,
  input  logic [DW/8-1:0]   host_mask_i,
  output logic [DW-1:0]     host_rdata_o,
  output logic              host_rvalid_o,
  input  logic [DW-1:0]     dq_i,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o,
  output logic [DW/8-1:0]   dqm_o
);
  localparam int MW    = DW / 8;
  localparam int CNT_W = ((CL_W > RCD_W) ? CL_W : RCD_W) + 1;

  logic [CNT_W-1:0] delay [2];
  logic [1:0]       start;
  logic [1:0]       fire;
  logic             wr_fire, rd_fire;

  // write beats load one cycle ahead of the pins; read beats sit on the pins
  assign delay[DIR_WR] = CNT_W'(cfg_rcd_i) - CNT_W'(1);
  assign delay[DIR_RD] = CNT_W'(cfg_rcd_i) + CNT_W'(cfg_cl_i);
  assign start[DIR_WR] = ack_i &  ack_wr_i;
  assign start[DIR_RD] = ack_i & ~ack_wr_i;

  for (genvar g = 0; g < 2; g++) begin : g_dir
    sdp_beat_timer #(.CNT_W(CNT_W), .BEAT_W(BL_W)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start[g]),
      .delay_i (delay[g]),
      .blen_i  (cfg_blen_i),
      .page_i  (cfg_page_i),
      .stop_i  (stop_i),
      .fire_o  (fire[g])
    );
  end

  assign wr_fire = fire[DIR_WR];
  assign rd_fire = fire[DIR_RD];

  sdp_wr_lane #(.DW(DW), .MW(MW)) i_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (start[DIR_WR]),
    .fire_i  (wr_fire),
    .wdata_i (host_wdata_i),
    .mask_i  (host_mask_i),
    .dq_o    (dq_o),
    .dqm_o   (dqm_o),
    .oe_o    (dq_oe_o)
  );

  sdp_rd_lane #(.DW(DW)) i_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (rd_fire),
    .dq_i     (dq_i),
    .rdata_o  (host_rdata_o),
    .rvalid_o (host_rvalid_o)
  );
endmodule

// File: rtl/sdram_dpath_chk.sv
module sdram_dpath_chk #(
  parameter int MW   = 4,
  parameter int BL_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_page_i,
  input logic [BL_W-1:0] cfg_blen_i,
  input logic            dq_oe_o,
  input logic [MW-1:0]   dqm_o,
  input logic            host_rvalid_o,
  input logic            wr_fire,
  input logic            rd_fire
);
  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (!dq_oe_o)          run_q <= '0;
    else if (run_q != 8'hFF)    run_q <= run_q + 8'd1;
  end

  a_r4_mask_only_in_beats: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe_o |-> (dqm_o == '0));

  a_r5_oe_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_o |-> $past(wr_fire));

  a_r6_valid_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid_o |-> $past(rd_fire, 2));

  a_r7_run_within_blen: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe_o && !cfg_page_i) |-> (run_q < 8'(cfg_blen_i)));

  a_r9_no_drive_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> !dq_oe_o);
endmodule

bind sdram_dpath sdram_dpath_chk #(.MW(DW/8), .BL_W(BL_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_page_i    (cfg_page_i),
  .cfg_blen_i    (cfg_blen_i),
  .dq_oe_o       (dq_oe_o),
  .dqm_o         (dqm_o),
  .host_rvalid_o (host_rvalid_o),
  .wr_fire       (wr_fire),
  .rd_fire       (rd_fire)
);

// File: tb/test_sdram_dpath.sv
`timescale 1ns/1ps
module test_sdram_dpath;
  localparam int DW = 32;
  localparam int MW = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ack_i, ack_wr_i, stop_i, cfg_page_i;
  logic [1:0]    cfg_cl_i, cfg_rcd_i;
  logic [3:0]    cfg_blen_i;
  logic [DW-1:0] host_wdata_i, dq_i, host_rdata_o, dq_o;
  logic [MW-1:0] host_mask_i, dqm_o;
  logic          host_rvalid_o, dq_oe_o;

  int n_chk  = 0;
  int n_fail = 0;
  int tnum   = 0;

  always #2.5 clk = ~clk;

  sdram_dpath #(.DW(DW)) i_sdram_dpath (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .ack_wr_i(ack_wr_i), .stop_i(stop_i),
    .cfg_cl_i(cfg_cl_i), .cfg_rcd_i(cfg_rcd_i), .cfg_blen_i(cfg_blen_i),
    .cfg_page_i(cfg_page_i), .host_wdata_i(host_wdata_i), .host_mask_i(host_mask_i),
    .host_rdata_o(host_rdata_o), .host_rvalid_o(host_rvalid_o), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dqm_o(dqm_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s test %0d: actual %0h expected %0h", req, tnum, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wword(input int t, input int k);
    return {8'(t), 8'(k), 8'h5A, 8'(t * 7 + k)};
  endfunction
  function automatic logic [DW-1:0] rword(input int t, input int k);
    return {8'(k), 8'hC3, 8'(t), 8'(t * 3 + k * 11)};
  endfunction
  function automatic logic [MW-1:0] mword(input int t, input int k);
    return MW'(k * 5 + t) ^ MW'(4'b0110);
  endfunction
  function automatic logic [DW-1:0] filler(input int j);
    return 32'hF00D_0000 | 32'(j);
  endfunction

  // write burst: loop index j is the cycle counted from the acknowledge cycle
  task automatic run_write(input int cl, input int rcd, input int blen, input bit page, input int m);
    int len;
    len = page ? m + 1 : blen;
    tnum++;
    cfg_cl_i = 2'(cl); cfg_rcd_i = 2'(rcd); cfg_blen_i = 4'(blen); cfg_page_i = page;
    for (int j = 0; j <= rcd + len + 3; j++) begin
      int k;
      bit oe_exp;
      @(negedge clk);
      k = j - rcd;
      oe_exp = (k >= 0) && (k < len);
      chk(dq_oe_o == oe_exp, page ? "R8 page write enable" : "R5/R7 write enable", 64'(dq_oe_o), 64'(oe_exp));
      if (oe_exp) begin
        chk(dq_o == wword(tnum, k), (k == 0) ? "R2 first write word" : "R3 later write word",
            64'(dq_o), 64'(wword(tnum, k)));
        chk(dqm_o == mword(tnum, k), "R4 write mask", 64'(dqm_o), 64'(mword(tnum, k)));
      end else begin
        chk(dqm_o == '0, "R4 mask idle", 64'(dqm_o), 64'd0);
      end
      chk(!host_rvalid_o, "R9 no read valid in write", 64'(host_rvalid_o), 64'd0);
      // inputs for cycle j
      ack_i = (j == 0);
      ack_wr_i = 1'b1;
      stop_i = page && (j == rcd - 1 + m);
      k = j - (rcd - 2);
      if (j == 0) begin
        host_wdata_i = wword(tnum, 0); host_mask_i = mword(tnum, 0);
      end else if (k >= 1 && k < len) begin
        host_wdata_i = wword(tnum, k); host_mask_i = mword(tnum, k);
      end else begin
        host_wdata_i = filler(j); host_mask_i = '1;
      end
    end
    ack_i = 1'b0; stop_i = 1'b0;
  endtask

  // read burst: pins carry beat k in cycle rcd+cl+k, host sees it two cycles later
  task automatic run_read(input int cl, input int rcd, input int blen, input bit page, input int m);
    int len;
    len = page ? m + 1 : blen;
    tnum++;
    cfg_cl_i = 2'(cl); cfg_rcd_i = 2'(rcd); cfg_blen_i = 4'(blen); cfg_page_i = page;
    for (int j = 0; j <= rcd + cl + len + 4; j++) begin
      int k;
      bit v_exp;
      @(negedge clk);
      k = j - rcd - cl - 2;
      v_exp = (k >= 0) && (k < len);
      chk(host_rvalid_o == v_exp, page ? "R8 page read valid" : "R6/R7 read valid",
          64'(host_rvalid_o), 64'(v_exp));
      if (v_exp)
        chk(host_rdata_o == rword(tnum, k), "R6/R10 read word", 64'(host_rdata_o), 64'(rword(tnum, k)));
      chk(!dq_oe_o && dqm_o == '0, "R9 pins quiet in read", 64'({dq_oe_o, dqm_o}), 64'd0);
      ack_i = (j == 0);
      ack_wr_i = 1'b0;
      host_mask_i = '0;
      host_wdata_i = filler(j);
      stop_i = page && (j == rcd + cl + m);
      k = j - rcd - cl;
      dq_i = (k >= 0 && k < len) ? rword(tnum, k) : filler(j);
    end
    ack_i = 1'b0; stop_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    ack_i = 1'b0; ack_wr_i = 1'b0; stop_i = 1'b0; cfg_page_i = 1'b0;
    cfg_cl_i = 2'd2; cfg_rcd_i = 2'd2; cfg_blen_i = 4'd1;
    host_wdata_i = '0; host_mask_i = '0; dq_i = '0;
    repeat (3) @(negedge clk);
    chk(!dq_oe_o && dqm_o == '0 && !host_rvalid_o, "R1 in reset",
        64'({dq_oe_o, dqm_o, host_rvalid_o}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!dq_oe_o && dqm_o == '0 && !host_rvalid_o, "R1 after reset",
        64'({dq_oe_o, dqm_o, host_rvalid_o}), 64'd0);
    for (int cl = 2; cl <= 3; cl++)
      for (int rcd = 2; rcd <= 3; rcd++)
        for (int b = 0; b < 4; b++) begin
          run_write(cl, rcd, 1 << b, 1'b0, 0);
          run_read(cl, rcd, 1 << b, 1'b0, 0);
        end
    for (int cl = 2; cl <= 3; cl++)
      for (int rcd = 2; rcd <= 3; rcd++) begin
        run_write(cl, rcd, 2, 1'b1, 0);
        run_write(cl, rcd, 2, 1'b1, 4);
        run_read(cl, rcd, 2, 1'b1, 0);
        run_read(cl, rcd, 2, 1'b1, 4);
      end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule